// File: doc/BRIEF.md
# Memory Write-Path ECC Fault Injector

This block sits between a memory controller's ECC encoder and the memory interface on the write path. It receives each write as an already-encoded code word plus its decoded location (module index within the channel, rank, channel, bank, page and column). When injection is armed and the location matches a programmed pattern, it flips a programmed set of bits in the lower half, the upper half or both halves of the word before passing it on. Alongside each corrupted word it raises class flags that tell the downstream logic whether an ECC-class error or a parity-class error was planted.

Software programs the block through a small word-addressed register port. Each of the six location fields has its own register holding a compare value and a separate "any" flag, so every numeric value stays usable as a real match value. Injection either fires once and disarms itself, or keeps firing on every matching write until software disarms it. Words leave the block one clock after they enter, whether or not they were touched.

Top module: `ecc_inject_unit`

## Requirements
- R1: After reset every location register reads 0x80000000 (any flag set, value 0), the mask, control and arm registers read 0, and `out_valid` is low.
- R2: Register addresses 0 to 5 hold module index, rank, channel, bank, page and column; each reads back with the any flag in bit 31 and the value in the low bits, with bits above the field width reading 0. Address 6 holds the flip mask (half a code word wide), address 7 holds control (bits 1:0 section, bit 2 repeat, bit 3 ECC class, bit 4 parity class), address 8 the arm bit in bit 0; other addresses read 0.
- R3: A valid write is corrupted only when the block is armed and each field whose any flag is clear equals the incoming value of that field.
- R4: A field whose any flag is set matches every incoming value of that field.
- R5: On injection the mask is XORed into bits [H-1:0] when section bit 0 is set and into bits [2H-1:H] when section bit 1 is set (H is half the word width); section 0 flips no bit but the injection is still reported.
- R6: Writing any nonzero value to the arm register arms the block and reads back as 1; writing zero disarms it, after which no write is corrupted.
- R7: With repeat clear, the block disarms itself on the first injection; writes that do not match, or cycles without a valid write, leave it armed.
- R8: With repeat set, every matching valid write is corrupted until software writes zero to the arm register.
- R9: `out_hit` marks each injected word; `out_ecc_err` and `out_par_err` follow the ECC and parity class bits only on injected words and are low otherwise.
- R10: `out_valid` follows `wr_valid` one clock later, and a word that is not injected leaves unchanged.
- R11: A register write to the arm address in the same clock as a one-shot injection takes effect over the self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data for `cfg_addr` (combinational) |
| wr_valid | input | 1 | Write word present |
| wr_dimm | input | DIMM_W | Module index within channel |
| wr_rank | input | RANK_W | Rank |
| wr_chan | input | CHAN_W | Channel |
| wr_bank | input | BANK_W | Bank |
| wr_page | input | PAGE_W | Page (row) address |
| wr_col | input | COL_W | Column address |
| wr_word | input | CW_W | Encoded code word |
| out_valid | output | 1 | Outgoing word present |
| out_word | output | CW_W | Outgoing, possibly corrupted, code word |
| out_hit | output | 1 | This word was injected |
| out_ecc_err | output | 1 | Injected word carries an ECC-class error |
| out_par_err | output | 1 | Injected word carries a parity-class error |

## Verification
The bench builds the block with one-bit module, rank and channel fields, a two-bit bank, a four-bit page, a three-bit column and a 16-bit code word split into two 8-bit halves. These widths put the all-ones value of every field, register write data wider than each field, and the full-width mask within a handful of cycles, so truncation on readback and both section halves are observed directly. Small fields also make a wildcard field's compare value sit among the values the bench drives, showing that the any flag and not the stored value decides the match.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  localparam int NUM_FIELDS = 6;
  localparam int ADDR_W     = 4;

  // register word addresses
  localparam logic [ADDR_W-1:0] RA_MASK   = 4'd6;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd7;
  localparam logic [ADDR_W-1:0] RA_ARM    = 4'd8;

  // bit positions inside the injection kind
  localparam int KIND_REPEAT = 0;
  localparam int KIND_ECC    = 1;
  localparam int KIND_PAR    = 2;

  typedef struct packed {
    logic [2:0] kind;     // control bits 4:2
    logic [1:0] section;  // control bits 1:0
  } inj_ctrl_t;

  localparam int CTRL_W = $bits(inj_ctrl_t);

endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int HALF_W = 32,
  parameter int FIELD_W [NUM_FIELDS] = '{2, 2, 2, 3, 18, 11},
  localparam int VAL_W = REG_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                fire,
  output logic [VAL_W-1:0]    fld_val [NUM_FIELDS],
  output logic                fld_any [NUM_FIELDS],
  output logic [HALF_W-1:0]   mask,
  output inj_ctrl_t           ctrl,
  output logic                armed
);

  logic [NUM_FIELDS-1:0] fld_we;
  logic                  mask_we;
  logic                  ctrl_we;
  logic                  arm_we;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      fld_we[i] = cfg_we && (cfg_addr == ADDR_W'(i));
    end
    mask_we = cfg_we && (cfg_addr == RA_MASK);
    ctrl_we = cfg_we && (cfg_addr == RA_CTRL);
    arm_we  = cfg_we && (cfg_addr == RA_ARM);
  end

  // location match registers, one per field
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [VAL_W-1:0] KEEP = (VAL_W'(1) << FIELD_W[g]) - VAL_W'(1);
    logic [VAL_W-1:0] val_d, val_q;
    logic             any_d, any_q;

    assign val_d = cfg_wdata[VAL_W-1:0] & KEEP;
    assign any_d = cfg_wdata[REG_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        any_q <= 1'b1;
      end else if (fld_we[g]) begin
        val_q <= val_d;
        any_q <= any_d;
      end
    end

    assign fld_val[g] = val_q;
    assign fld_any[g] = any_q;
  end

  // mask and control
  logic [HALF_W-1:0] mask_q;
  inj_ctrl_t         ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= cfg_wdata[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= cfg_wdata[CTRL_W-1:0];
    end
  end

  // arm bit: software write wins over the one-shot self-clear
  logic arm_d, arm_q, arm_upd;

  always_comb begin
    arm_d = arm_q;
    if (arm_we) begin
      arm_d = |cfg_wdata;
    end else if (fire && !ctrl_q.kind[KIND_REPEAT]) begin
      arm_d = 1'b0;
    end
  end

  assign arm_upd = arm_we | fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (arm_upd) begin
      arm_q <= arm_d;
    end
  end

  // readback
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (cfg_addr == ADDR_W'(i)) begin
        cfg_rdata = {fld_any[i], fld_val[i]};
      end
    end
    if (cfg_addr == RA_MASK) cfg_rdata = REG_W'(mask_q);
    if (cfg_addr == RA_CTRL) cfg_rdata = REG_W'(ctrl_q);
    if (cfg_addr == RA_ARM)  cfg_rdata = REG_W'(arm_q);
  end

  assign mask  = mask_q;
  assign ctrl  = ctrl_q;
  assign armed = arm_q;

endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
  import ecc_inj_pkg::*;
#(
  parameter int VAL_W = 31
) (
  input  logic [VAL_W-1:0] fld_val [NUM_FIELDS],
  input  logic             fld_any [NUM_FIELDS],
  input  logic [VAL_W-1:0] req_val [NUM_FIELDS],
  output logic             hit
);

  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign field_ok[g] = fld_any[g] | (fld_val[g] == req_val[g]);
  end

  assign hit = &field_ok;

endmodule

// File: rtl/ecc_inj_corrupt.sv
module ecc_inj_corrupt
  import ecc_inj_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CW_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CW_W-1:0]   in_word,
  input  logic              fire,
  input  logic [HALF_W-1:0] mask,
  input  logic [1:0]        section,
  input  logic              ecc_kind,
  input  logic              par_kind,
  output logic              out_valid,
  output logic [CW_W-1:0]   out_word,
  output logic              out_hit,
  output logic              out_ecc,
  output logic              out_par
);

  logic [CW_W-1:0] flip;

  // one mask copy per half, gated by its section bit
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign flip[h*HALF_W +: HALF_W] = (fire && section[h]) ? mask : '0;
  end

  logic [CW_W-1:0] word_d;
  logic            hit_d, ecc_d, par_d;

  always_comb begin
    word_d = in_word ^ flip;
    hit_d  = fire;
    ecc_d  = fire & ecc_kind;
    par_d  = fire & par_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_ecc   <= 1'b0;
      out_par   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= hit_d;
      out_ecc   <= ecc_d;
      out_par   <= par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word <= '0;
    end else if (in_valid) begin
      out_word <= word_d;
    end
  end

endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
  import ecc_inj_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int CW_W   = 64,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 18,
  parameter int COL_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              wr_valid,
  input  logic [DIMM_W-1:0] wr_dimm,
  input  logic [RANK_W-1:0] wr_rank,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [CW_W-1:0]   wr_word,
  output logic              out_valid,
  output logic [CW_W-1:0]   out_word,
  output logic              out_hit,
  output logic              out_ecc_err,
  output logic              out_par_err
);

  localparam int HALF_W = CW_W / 2;
  localparam int VAL_W  = REG_W - 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [VAL_W-1:0]  fld_val [NUM_FIELDS];
  logic              fld_any [NUM_FIELDS];
  logic [VAL_W-1:0]  req_val [NUM_FIELDS];
  logic [HALF_W-1:0] mask;
  inj_ctrl_t         ctrl;
  logic              inj_en;
  logic              addr_hit;
  logic              fire;
  logic              repeat_on;

  assign req_val[0] = VAL_W'(wr_dimm);
  assign req_val[1] = VAL_W'(wr_rank);
  assign req_val[2] = VAL_W'(wr_chan);
  assign req_val[3] = VAL_W'(wr_bank);
  assign req_val[4] = VAL_W'(wr_page);
  assign req_val[5] = VAL_W'(wr_col);

  ecc_inj_regs #(
    .REG_W   (REG_W),
    .HALF_W  (HALF_W),
    .FIELD_W ('{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W})
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fire      (fire),
    .fld_val   (fld_val),
    .fld_any   (fld_any),
    .mask      (mask),
    .ctrl      (ctrl),
    .armed     (inj_en)
  );

  ecc_inj_match #(
    .VAL_W (VAL_W)
  ) u_match (
    .fld_val (fld_val),
    .fld_any (fld_any),
    .req_val (req_val),
    .hit     (addr_hit)
  );

  assign fire      = wr_valid & inj_en & addr_hit;
  assign repeat_on = ctrl.kind[KIND_REPEAT];

  ecc_inj_corrupt #(
    .HALF_W (HALF_W)
  ) u_corrupt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (wr_valid),
    .in_word   (wr_word),
    .fire      (fire),
    .mask      (mask),
    .section   (ctrl.section),
    .ecc_kind  (ctrl.kind[KIND_ECC]),
    .par_kind  (ctrl.kind[KIND_PAR]),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_hit   (out_hit),
    .out_ecc   (out_ecc_err),
    .out_par   (out_par_err)
  );

endmodule

// File: rtl/ecc_inject_unit_chk.sv
module ecc_inject_unit_chk #(
  parameter int CW_W = 64
) (
  input logic            clk,
  input logic            rst_q,
  input logic            cfg_we,
  input logic [3:0]      cfg_addr,
  input logic            wr_valid,
  input logic [CW_W-1:0] wr_word,
  input logic            out_valid,
  input logic [CW_W-1:0] out_word,
  input logic            out_hit,
  input logic            out_ecc_err,
  input logic            out_par_err,
  input logic            inj_en,
  input logic            addr_hit,
  input logic            repeat_on
);

  logic arm_write;
  assign arm_write = cfg_we && (cfg_addr == 4'd8);

  p_disarmed_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (!inj_en && wr_valid) |=> !out_hit);

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_valid && addr_hit && inj_en && !repeat_on && !arm_write) |=> !inj_en);

  p_keep_armed_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (inj_en && repeat_on && !arm_write) |=> inj_en);

  p_arm_wins_r11: assert property (@(posedge clk) disable iff (!rst_q)
    (arm_write && wr_valid && addr_hit && inj_en && !repeat_on) |=> inj_en);

  p_flag_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (out_ecc_err || out_par_err) |-> out_hit);

  p_hit_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_q)
    out_hit |-> out_valid);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_q)
    wr_valid |=> out_valid);

  p_idle_follows_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_valid |=> !out_valid);

  p_clean_pass_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_valid && !(inj_en && addr_hit)) |=> (out_word == $past(wr_word)));

endmodule

bind ecc_inject_unit ecc_inject_unit_chk #(.CW_W(CW_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_sync_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .wr_valid    (wr_valid),
  .wr_word     (wr_word),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .out_hit     (out_hit),
  .out_ecc_err (out_ecc_err),
  .out_par_err (out_par_err),
  .inj_en      (inj_en),
  .addr_hit    (addr_hit),
  .repeat_on   (repeat_on)
);

// File: tb/ecc_inject_unit_test.sv
`timescale 1ns/1ps
module ecc_inject_unit_test;

  localparam int REG_W = 32;
  localparam int CW_W  = 16;

  logic             clk;
  logic             rst_n;
  logic             cfg_we;
  logic [3:0]       cfg_addr;
  logic [REG_W-1:0] cfg_wdata;
  logic [REG_W-1:0] cfg_rdata;
  logic             wr_valid;
  logic             wr_dimm, wr_rank, wr_chan;
  logic [1:0]       wr_bank;
  logic [3:0]       wr_page;
  logic [2:0]       wr_col;
  logic [CW_W-1:0]  wr_word;
  logic             out_valid;
  logic [CW_W-1:0]  out_word;
  logic             out_hit, out_ecc_err, out_par_err;

  ecc_inject_unit #(
    .REG_W(REG_W), .CW_W(CW_W), .DIMM_W(1), .RANK_W(1), .CHAN_W(1),
    .BANK_W(2), .PAGE_W(4), .COL_W(3)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_valid(wr_valid),
    .wr_dimm(wr_dimm), .wr_rank(wr_rank), .wr_chan(wr_chan),
    .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
    .wr_word(wr_word), .out_valid(out_valid), .out_word(out_word),
    .out_hit(out_hit), .out_ecc_err(out_ecc_err), .out_par_err(out_par_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  // {dimm, rank, chan, bank, page, col, word, injected}
  localparam logic [28:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 2'd2, 4'd3,  3'd5, 16'h1234, 1'b1},
    {1'b1, 1'b1, 1'b0, 2'd2, 4'd15, 3'd5, 16'hBEEF, 1'b1},
    {1'b0, 1'b0, 1'b0, 2'd2, 4'd0,  3'd5, 16'h1234, 1'b0},
    {1'b1, 1'b0, 1'b1, 2'd2, 4'd0,  3'd5, 16'h1234, 1'b0},
    {1'b1, 1'b0, 1'b0, 2'd3, 4'd0,  3'd5, 16'h1234, 1'b0},
    {1'b1, 1'b0, 1'b0, 2'd2, 4'd0,  3'd4, 16'h1234, 1'b0},
    {1'b1, 1'b1, 1'b0, 2'd2, 4'd9,  3'd5, 16'hFFFF, 1'b1},
    {1'b1, 1'b0, 1'b0, 2'd2, 4'd0,  3'd5, 16'h0000, 1'b1}
  };

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic drive(input logic [28:0] v, input logic vld);
    wr_dimm = v[28]; wr_rank = v[27]; wr_chan = v[26]; wr_bank = v[25:24];
    wr_page = v[23:20]; wr_col = v[19:17]; wr_word = v[16:1];
    wr_valid = vld;
  endtask

  // present one write at a falling edge, sample after the next rising edge
  task automatic send(input logic [28:0] v, input logic vld);
    @(negedge clk);
    drive(v, vld);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  localparam logic [28:0] HITV = {1'b1, 1'b0, 1'b0, 2'd2, 4'd0, 3'd5, 16'h0000, 1'b0};
  localparam logic [28:0] MISV = {1'b0, 1'b0, 1'b0, 2'd2, 4'd0, 3'd5, 16'h3C3C, 1'b0};

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    drive('0, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      cfg_read(4'(a), rd);
      chk("R1 field reset", rd, 32'h8000_0000);
    end
    for (int a = 6; a < 9; a++) begin
      cfg_read(4'(a), rd);
      chk("R1 cfg reset", rd, 32'h0);
    end
    chk("R1 out_valid reset", {31'b0, out_valid}, 32'h0);

    // R2 readback truncation
    cfg_write(4'd4, 32'hFFFF_FFFF);
    cfg_read(4'd4, rd);  chk("R2 page readback", rd, 32'h8000_000F);
    cfg_write(4'd5, 32'h0000_00FF);
    cfg_read(4'd5, rd);  chk("R2 column readback", rd, 32'h0000_0007);
    cfg_write(4'd6, 32'hFFFF_FFFF);
    cfg_read(4'd6, rd);  chk("R2 mask readback", rd, 32'h0000_00FF);
    cfg_write(4'd7, 32'hFFFF_FFFF);
    cfg_read(4'd7, rd);  chk("R2 control readback", rd, 32'h0000_001F);
    cfg_read(4'd9, rd);  chk("R2 unused address", rd, 32'h0);

    // table setup: dimm 1, rank any, chan 0, bank 2, page any, col 5
    cfg_write(4'd0, 32'h1);
    cfg_write(4'd2, 32'h0);
    cfg_write(4'd3, 32'h2);
    cfg_write(4'd4, 32'h8000_0000);
    cfg_write(4'd5, 32'h5);
    cfg_write(4'd6, 32'hA5);
    cfg_write(4'd7, 32'h0F);   // both halves, repeat, ECC class
    cfg_write(4'd8, 32'h1);

    // R3 R4 R8 R9 R10 table
    for (int k = 0; k < 8; k++) begin
      logic [28:0] v;
      logic [15:0] expw;
      v = VEC[k];
      expw = v[0] ? (v[16:1] ^ 16'hA5A5) : v[16:1];
      send(v, 1'b1);
      chk("R10 out_valid", {31'b0, out_valid}, 32'h1);
      chk("R3 R4 word", {16'b0, out_word}, {16'b0, expw});
      chk("R9 hit", {31'b0, out_hit}, {31'b0, v[0]});
      chk("R9 ecc flag", {31'b0, out_ecc_err}, {31'b0, v[0]});
      chk("R9 parity flag", {31'b0, out_par_err}, 32'h0);
    end
    cfg_read(4'd8, rd); chk("R8 still armed", rd, 32'h1);

    // R10 no valid write
    @(negedge clk);
    chk("R10 idle", {31'b0, out_valid}, 32'h0);

    // R6 disarm
    cfg_write(4'd8, 32'h0);
    send(HITV, 1'b1);
    chk("R6 disarmed hit", {31'b0, out_hit}, 32'h0);
    chk("R6 disarmed word", {16'b0, out_word}, 32'h0);

    // R5 sections
    cfg_write(4'd8, 32'h1);
    cfg_write(4'd7, 32'h0D);
    send(HITV, 1'b1); chk("R5 lower half", {16'b0, out_word}, 32'h00A5);
    cfg_write(4'd7, 32'h0E);
    send(HITV, 1'b1); chk("R5 upper half", {16'b0, out_word}, 32'hA500);
    cfg_write(4'd7, 32'h0C);
    send(HITV, 1'b1);
    chk("R5 section zero word", {16'b0, out_word}, 32'h0000);
    chk("R5 section zero hit", {31'b0, out_hit}, 32'h1);

    // R9 parity class
    cfg_write(4'd7, 32'h17);
    send(HITV, 1'b1);
    chk("R9 parity set", {31'b0, out_par_err}, 32'h1);
    chk("R9 ecc clear", {31'b0, out_ecc_err}, 32'h0);
    chk("R9 parity word", {16'b0, out_word}, 32'hA5A5);

    // R6 R7 one-shot
    cfg_write(4'd7, 32'h0B);
    cfg_write(4'd8, 32'h40);
    cfg_read(4'd8, rd); chk("R6 nonzero arms", rd, 32'h1);
    send(MISV, 1'b1);
    chk("R7 miss no hit", {31'b0, out_hit}, 32'h0);
    chk("R7 miss word", {16'b0, out_word}, 32'h3C3C);
    cfg_read(4'd8, rd); chk("R7 miss keeps armed", rd, 32'h1);
    send(HITV, 1'b0);
    chk("R10 no valid out", {31'b0, out_valid}, 32'h0);
    cfg_read(4'd8, rd); chk("R7 idle keeps armed", rd, 32'h1);
    send(HITV, 1'b1);
    chk("R7 first hit", {31'b0, out_hit}, 32'h1);
    cfg_read(4'd8, rd); chk("R7 self-clear", rd, 32'h0);
    send(HITV, 1'b1);
    chk("R7 second not hit", {31'b0, out_hit}, 32'h0);
    chk("R7 second word", {16'b0, out_word}, 32'h0);

    // R11 arm write beats self-clear
    cfg_write(4'd8, 32'h1);
    @(negedge clk);
    drive(HITV, 1'b1);
    cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 32'h1;
    @(negedge clk);
    wr_valid = 1'b0; cfg_we = 1'b0;
    chk("R11 injected", {31'b0, out_hit}, 32'h1);
    cfg_read(4'd8, rd); chk("R11 stays armed", rd, 32'h1);

    report();
  end

endmodule